// File: doc/BRIEF.md
# Scoreboard Issue Hazard Checker

This block is the central issue controller of a small in-order machine. The machine has several functional units and one architectural register file with no renaming. Each decoded instruction arrives with two source register numbers, a destination register number and a unit selector. The block makes three decisions:

- whether the instruction may be assigned to its unit;
- when an assigned instruction may read its operands;
- when a finished instruction may write its result.

It keeps a pending-writer entry for each register and a small record for each unit. Each unit record holds that unit's source registers, the producers the unit still waits on, and a latency countdown.

Instructions enter over a valid/ready handshake and are accepted on a cycle where both are high. `in_ready` depends only on the offered payload and the internal state, never on `in_valid`. The offered payload must therefore stay stable while `in_valid` is high and `in_ready` is low.

Two conditions stall assignment of the offered instruction. One is a busy target unit. The other is a write-after-write clash with an in-flight instruction. The WAW stall freezes the whole stream, so no unit receives anything until the older writer has retired. A write-after-read clash is handled differently. Only the finished unit's write-back is held, and other units keep accepting and running instructions.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset, all units are idle. `rd_go`, `wb_go`, `war_hold` and both stall flags are low, and a hazard-free offer sees `in_ready` high.
- R2: An offered instruction is accepted when its unit (selected by `in_unit`, unit i has latency LAT_MIN + i*LAT_STEP, giving 1, 2, 3, 4 by default) is idle and its destination has no pending writer. The unit's `unit_busy` bit is high in the following cycle.
- R3: While the selected unit is busy, `in_ready` is low and `stall_unit_busy` is high.
- R4: While the offered destination is the destination of an in-flight instruction, `in_ready` is low and `stall_waw` is high, even if the selected unit is idle.
- R5: An instruction whose source is written by an earlier in-flight instruction keeps `rd_go` low. `rd_go` rises in the cycle after the producer's `wb_go`.
- R6: An instruction with no pending sources asserts `rd_go` in the cycle right after its acceptance.
- R7: A unit of latency L asserts `wb_go` exactly L cycles after its `rd_go` cycle, unless held by R8.
- R8: A finished unit whose destination matches a source that an earlier, still-unread instruction needs keeps `war_hold` high and `wb_go` low. It writes in the cycle after that reader's `rd_go`.
- R9: While a unit is held by `war_hold`, an instruction for another idle unit with no WAW clash is accepted.
- R10: `unit_busy` falls in the cycle after `wb_go`. A WAW-stalled instruction is accepted in the cycle after the older writer's `wb_go`.
- R11: `rd_go` and `wb_go` are each a single-cycle pulse per instruction.
- R12: An instruction accepted after a writer, and reading that writer's destination, waits on the writer (R5) and never causes `war_hold` on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Offered instruction is valid |
| in_ready | output | 1 | Offered instruction may be accepted this cycle |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| in_dst | input | RW | Destination register |
| in_unit | input | UW | Target functional unit |
| stall_waw | output | 1 | Offer blocked by a pending writer of its destination |
| stall_unit_busy | output | 1 | Offer blocked by a busy target unit |
| unit_busy | output | NUNIT | Per-unit occupancy |
| rd_go | output | NUNIT | Per-unit operand read permission pulse |
| wb_go | output | NUNIT | Per-unit result write / completion pulse |
| war_hold | output | NUNIT | Per-unit result write held by a WAR conflict |

## Verification
The bench aims at the edges where a scoreboard usually slips.

- **Late reader.** An instruction issued after a writer must not count as an earlier reader of that writer's register. A design that compared registers without remembering the producer would deadlock or hold the write.
- **WAR hold.** A held writer must still let other units take new work. A design that turned the hold into a global freeze would drop `in_ready` there.
- **Off-by-one points.** The bench checks `rd_go` and `wb_go` at their exact cycles across all four latencies, after WAW and structural stalls, and after RAW release. A design with an extra register in the release path, or one that issued a stalled instruction in the same cycle as the completion, would shift these points by one.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Life cycle of one functional-unit record.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // no instruction assigned
    PH_OPS  = 2'd1,  // assigned, waiting to read operands
    PH_EXEC = 2'd2,  // operands read, latency countdown running
    PH_WB   = 2'd3   // result ready, waiting for write permission
  } slot_phase_e;

endpackage

// File: rtl/sb_pending_table.sv
module sb_pending_table #(
  parameter int NREG  = 8,
  parameter int NUNIT = 4,
  localparam int RW = $clog2(NREG),
  localparam int UW = $clog2(NUNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [RW-1:0]    set_reg,
  input  logic [UW-1:0]    set_unit,
  input  logic [NUNIT-1:0] done_mask,
  input  logic [RW-1:0]    lk_a_reg,
  input  logic [RW-1:0]    lk_b_reg,
  input  logic [RW-1:0]    lk_d_reg,
  output logic             lk_a_v,
  output logic [UW-1:0]    lk_a_id,
  output logic             lk_b_v,
  output logic [UW-1:0]    lk_b_id,
  output logic             lk_d_v
);

  logic [NREG-1:0] pend_v_q;
  logic [UW-1:0]   pend_id_q [NREG];

  // One writer per register at most; a completion frees the entry it owns.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        pend_v_q[r]  <= 1'b0;
        pend_id_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_en && set_reg == RW'(r)) begin
          pend_v_q[r]  <= 1'b1;
          pend_id_q[r] <= set_unit;
        end else if (pend_v_q[r] && done_mask[pend_id_q[r]]) begin
          pend_v_q[r] <= 1'b0;
        end
      end
    end
  end

  assign lk_a_v  = pend_v_q[lk_a_reg];
  assign lk_a_id = pend_id_q[lk_a_reg];
  assign lk_b_v  = pend_v_q[lk_b_reg];
  assign lk_b_id = pend_id_q[lk_b_reg];
  assign lk_d_v  = pend_v_q[lk_d_reg];

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !pend_v_q[set_reg]) else $error("second writer claimed a register"); // R4

endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NUNIT = 4,
  parameter int LAT   = 1,
  parameter int CW    = 3,
  localparam int RW = $clog2(NREG),
  localparam int UW = $clog2(NUNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [RW-1:0]    is_src_a,
  input  logic [RW-1:0]    is_src_b,
  input  logic [RW-1:0]    is_dst,
  input  logic             is_qa_v,
  input  logic [UW-1:0]    is_qa_id,
  input  logic             is_qb_v,
  input  logic [UW-1:0]    is_qb_id,
  input  logic [NUNIT-1:0] done_mask,
  input  logic             war_block,
  output logic             busy,
  output logic             rd_go,
  output logic             want_wb,
  output logic             wb_go,
  output logic [RW-1:0]    dst_o,
  output logic             unread_a,
  output logic             unread_b,
  output logic [RW-1:0]    src_a_o,
  output logic [RW-1:0]    src_b_o
);

  slot_phase_e   phase_q;
  logic [RW-1:0] sa_q, sb_q, dst_q;
  logic          qa_v_q, qb_v_q;
  logic [UW-1:0] qa_id_q, qb_id_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sa_q    <= '0;
      sb_q    <= '0;
      dst_q   <= '0;
      qa_v_q  <= 1'b0;
      qb_v_q  <= 1'b0;
      qa_id_q <= '0;
      qb_id_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (issue_en) begin
            phase_q <= PH_OPS;
            sa_q    <= is_src_a;
            sb_q    <= is_src_b;
            dst_q   <= is_dst;
            qa_v_q  <= is_qa_v;
            qa_id_q <= is_qa_id;
            qb_v_q  <= is_qb_v;
            qb_id_q <= is_qb_id;
          end
        end
        PH_OPS: begin
          if (qa_v_q && done_mask[qa_id_q]) qa_v_q <= 1'b0;
          if (qb_v_q && done_mask[qb_id_q]) qb_v_q <= 1'b0;
          if (rd_go) begin
            cnt_q   <= CW'(LAT - 1);
            phase_q <= (LAT == 1) ? PH_WB : PH_EXEC;
          end
        end
        PH_EXEC: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) phase_q <= PH_WB;
        end
        PH_WB: begin
          if (wb_go) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign rd_go    = (phase_q == PH_OPS) && !qa_v_q && !qb_v_q;
  assign want_wb  = (phase_q == PH_WB);
  assign wb_go    = want_wb && !war_block;
  assign dst_o    = dst_q;
  assign src_a_o  = sa_q;
  assign src_b_o  = sb_q;
  assign unread_a = (phase_q == PH_OPS) && !qa_v_q;
  assign unread_b = (phase_q == PH_OPS) && !qb_v_q;

  AST_ISSUE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> !busy) else $error("assignment to an occupied unit"); // R3
  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> busy) else $error("accepted instruction not recorded"); // R2
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go) else $error("operand read repeated"); // R11
  AST_WB_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |=> !busy) else $error("unit still busy after completion"); // R10
  AST_WB_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_go) |-> $past(phase_q) != PH_OPS || LAT == 1) else $error("write before latency"); // R7

endmodule

// File: rtl/sb_war_check.sv
module sb_war_check #(
  parameter int NREG  = 8,
  parameter int NUNIT = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic [NUNIT-1:0] want_wb,
  input  logic [RW-1:0]    dst    [NUNIT],
  input  logic [NUNIT-1:0] unread_a,
  input  logic [NUNIT-1:0] unread_b,
  input  logic [RW-1:0]    src_a  [NUNIT],
  input  logic [RW-1:0]    src_b  [NUNIT],
  output logic [NUNIT-1:0] war_hold
);

  // A source that is unread and not waiting on a producer belongs to an
  // instruction older than any current writer of that register.
  for (genvar u = 0; u < NUNIT; u++) begin : g_writer
    logic clash;
    always_comb begin
      clash = 1'b0;
      for (int v = 0; v < NUNIT; v++) begin
        if (v != u) begin
          if (unread_a[v] && src_a[v] == dst[u]) clash = 1'b1;
          if (unread_b[v] && src_b[v] == dst[u]) clash = 1'b1;
        end
      end
    end
    assign war_hold[u] = want_wb[u] && clash;
  end

endmodule

// File: rtl/scoreboard_issue.sv
module scoreboard_issue #(
  parameter int NREG     = 8,
  parameter int NUNIT    = 4,
  parameter int LAT_MIN  = 1,
  parameter int LAT_STEP = 1,
  localparam int RW      = $clog2(NREG),
  localparam int UW      = $clog2(NUNIT),
  localparam int LAT_MAX = LAT_MIN + (NUNIT - 1) * LAT_STEP,
  localparam int CW      = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RW-1:0]    in_src_a,
  input  logic [RW-1:0]    in_src_b,
  input  logic [RW-1:0]    in_dst,
  input  logic [UW-1:0]    in_unit,
  output logic             stall_waw,
  output logic             stall_unit_busy,
  output logic [NUNIT-1:0] unit_busy,
  output logic [NUNIT-1:0] rd_go,
  output logic [NUNIT-1:0] wb_go,
  output logic [NUNIT-1:0] war_hold
);

  logic          lk_a_v, lk_b_v, lk_d_v;
  logic [UW-1:0] lk_a_id, lk_b_id;
  logic          accept;
  logic          cap_qa_v, cap_qb_v;

  logic [NUNIT-1:0] want_wb, unread_a, unread_b;
  logic [RW-1:0]    u_dst   [NUNIT];
  logic [RW-1:0]    u_src_a [NUNIT];
  logic [RW-1:0]    u_src_b [NUNIT];

  sb_pending_table #(.NREG(NREG), .NUNIT(NUNIT)) i_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (accept),
    .set_reg  (in_dst),
    .set_unit (in_unit),
    .done_mask(wb_go),
    .lk_a_reg (in_src_a),
    .lk_b_reg (in_src_b),
    .lk_d_reg (in_dst),
    .lk_a_v   (lk_a_v),
    .lk_a_id  (lk_a_id),
    .lk_b_v   (lk_b_v),
    .lk_b_id  (lk_b_id),
    .lk_d_v   (lk_d_v)
  );

  // WAW freezes the whole stream; the unit check is purely structural.
  assign in_ready        = !unit_busy[in_unit] && !lk_d_v;
  assign accept          = in_valid && in_ready;
  assign stall_waw       = in_valid && lk_d_v;
  assign stall_unit_busy = in_valid && unit_busy[in_unit];

  // A producer retiring in the acceptance cycle is already resolved.
  assign cap_qa_v = lk_a_v && !wb_go[lk_a_id];
  assign cap_qb_v = lk_b_v && !wb_go[lk_b_id];

  for (genvar i = 0; i < NUNIT; i++) begin : g_unit
    sb_unit_slot #(
      .NREG (NREG),
      .NUNIT(NUNIT),
      .LAT  (LAT_MIN + i * LAT_STEP),
      .CW   (CW)
    ) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_en (accept && in_unit == UW'(i)),
      .is_src_a (in_src_a),
      .is_src_b (in_src_b),
      .is_dst   (in_dst),
      .is_qa_v  (cap_qa_v),
      .is_qa_id (lk_a_id),
      .is_qb_v  (cap_qb_v),
      .is_qb_id (lk_b_id),
      .done_mask(wb_go),
      .war_block(war_hold[i]),
      .busy     (unit_busy[i]),
      .rd_go    (rd_go[i]),
      .want_wb  (want_wb[i]),
      .wb_go    (wb_go[i]),
      .dst_o    (u_dst[i]),
      .unread_a (unread_a[i]),
      .unread_b (unread_b[i]),
      .src_a_o  (u_src_a[i]),
      .src_b_o  (u_src_b[i])
    );
  end

  sb_war_check #(.NREG(NREG), .NUNIT(NUNIT)) i_war (
    .want_wb (want_wb),
    .dst     (u_dst),
    .unread_a(unread_a),
    .unread_b(unread_b),
    .src_a   (u_src_a),
    .src_b   (u_src_b),
    .war_hold(war_hold)
  );

  AST_HOLD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (war_hold & wb_go) == '0) else $error("held unit wrote its result"); // R8
  AST_WAW_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    stall_waw |=> $stable(unit_busy) || (|$past(wb_go))) else $error("assignment during WAW freeze"); // R4

endmodule

// File: tb/test_scoreboard_issue.sv
module test_scoreboard_issue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [1:0] in_unit = '0;
  logic       stall_waw, stall_unit_busy;
  logic [3:0] unit_busy, rd_go, wb_go, war_hold;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  scoreboard_issue i_scoreboard_issue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_unit(in_unit),
    .stall_waw(stall_waw), .stall_unit_busy(stall_unit_busy), .unit_busy(unit_busy),
    .rd_go(rd_go), .wb_go(wb_go), .war_hold(war_hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input bit v, input int u, input int a, input int b, input int d);
    in_valid = v;
    in_unit  = 2'(u);
    in_src_a = 3'(a);
    in_src_b = 3'(b);
    in_dst   = 3'(d);
  endtask

  // Offer at the current negedge and expect acceptance.
  task automatic issue(input string req, input int u, input int a, input int b, input int d);
    @(negedge clk);
    put(1'b1, u, a, b, d);
    #1;
    chk({req, " in_ready on hazard-free offer"}, int'(in_ready), 1);
  endtask

  task automatic idle_step();
    @(negedge clk);
    put(1'b0, 0, 0, 0, 0);
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 10; k++) idle_step();
    chk("R10 all units idle after drain", int'(unit_busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    put(1'b1, 2, 1, 2, 3);
    #1;
    chk("R1 unit_busy after reset", int'(unit_busy), 0);
    chk("R1 rd_go after reset", int'(rd_go), 0);
    chk("R1 wb_go after reset", int'(wb_go), 0);
    chk("R1 war_hold after reset", int'(war_hold), 0);
    chk("R1 stall_waw after reset", int'(stall_waw), 0);
    chk("R1 stall_unit_busy after reset", int'(stall_unit_busy), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    put(1'b0, 0, 0, 0, 0);
  endtask

  // Every unit alone: read right after issue, write L cycles later.
  task automatic t_latency();
    for (int u = 0; u < 4; u++) begin
      issue("R2", u, 6, 7, u + 1);
      for (int k = 1; k <= u + 4; k++) begin
        idle_step();
        chk($sformatf("R6 R11 rd_go unit%0d k=%0d", u, k), int'(rd_go[u]), int'(k == 1));
        chk($sformatf("R7 R11 wb_go unit%0d k=%0d", u, k), int'(wb_go[u]), int'(k == u + 2));
        chk($sformatf("R2 R10 unit_busy unit%0d k=%0d", u, k), int'(unit_busy[u]), int'(k <= u + 2));
      end
      drain();
    end
  endtask

  task automatic t_struct();
    issue("R2", 3, 0, 0, 1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      put(1'b1, 3, 2, 2, 3);
      #1;
      chk($sformatf("R3 in_ready k=%0d", k), int'(in_ready), int'(k == 6));
      chk($sformatf("R3 stall_unit_busy k=%0d", k), int'(stall_unit_busy), int'(k < 6));
    end
    drain();
  endtask

  task automatic t_raw();
    issue("R2", 3, 0, 0, 5);
    issue("R2", 0, 5, 1, 6);
    for (int k = 2; k <= 8; k++) begin
      idle_step();
      chk($sformatf("R5 rd_go consumer k=%0d", k), int'(rd_go[0]), int'(k == 6));
      chk($sformatf("R7 wb_go producer k=%0d", k), int'(wb_go[3]), int'(k == 5));
      chk($sformatf("R7 wb_go consumer k=%0d", k), int'(wb_go[0]), int'(k == 7));
    end
    drain();
  endtask

  task automatic t_waw();
    issue("R2", 3, 0, 0, 2);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      put(1'b1, 0, 4, 4, 2);
      #1;
      chk($sformatf("R4 R10 in_ready k=%0d", k), int'(in_ready), int'(k == 6));
      chk($sformatf("R4 stall_waw k=%0d", k), int'(stall_waw), int'(k < 6));
      chk($sformatf("R4 stall_unit_busy k=%0d", k), int'(stall_unit_busy), 0);
    end
    for (int k = 7; k <= 8; k++) begin
      idle_step();
      chk($sformatf("R6 rd_go after WAW k=%0d", k), int'(rd_go[0]), int'(k == 7));
      chk($sformatf("R7 wb_go after WAW k=%0d", k), int'(wb_go[0]), int'(k == 8));
    end
    drain();
  endtask

  task automatic t_war();
    issue("R2", 3, 0, 0, 1);
    issue("R2", 2, 1, 3, 4);
    issue("R2", 0, 5, 5, 3);
    idle_step();
    chk("R6 rd_go writer k=3", int'(rd_go[0]), 1);
    issue("R9", 1, 7, 7, 6);
    chk("R8 war_hold k=4", int'(war_hold[0]), 1);
    for (int k = 5; k <= 10; k++) begin
      idle_step();
      chk($sformatf("R8 war_hold k=%0d", k), int'(war_hold[0]), int'(k <= 6));
      chk($sformatf("R8 wb_go held writer k=%0d", k), int'(wb_go[0]), int'(k == 7));
      chk($sformatf("R5 rd_go reader k=%0d", k), int'(rd_go[2]), int'(k == 6));
      chk($sformatf("R9 wb_go other unit k=%0d", k), int'(wb_go[1]), int'(k == 7));
      chk($sformatf("R7 wb_go reader k=%0d", k), int'(wb_go[2]), int'(k == 9));
    end
    drain();
  endtask

  task automatic t_later_reader();
    issue("R2", 0, 0, 0, 4);
    issue("R12", 3, 4, 4, 5);
    for (int k = 2; k <= 8; k++) begin
      idle_step();
      chk($sformatf("R12 war_hold k=%0d", k), int'(war_hold[0]), 0);
      chk($sformatf("R12 wb_go writer k=%0d", k), int'(wb_go[0]), int'(k == 2));
      chk($sformatf("R5 rd_go later reader k=%0d", k), int'(rd_go[3]), int'(k == 3));
      chk($sformatf("R7 wb_go later reader k=%0d", k), int'(wb_go[3]), int'(k == 7));
    end
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_struct();
    t_raw();
    t_waw();
    t_war();
    t_later_reader();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule